// File: doc/BRIEF.md
# Processor Powerdown Sequencer

This controller takes a processor core into a low-power standby state and brings it back out. A standby request comes from an external pin or from a software force bit, whichever rises first. The request does not stop the core straight away. It first raises a one-cycle interrupt pulse. The core can then run as much code as it needs before it signals, on a commit input, that it is ready to stop. From that point the core clock is held off. The oscillator and the external clock output may also be turned off, depending on two mode bits.

A wake request ends standby. A software reset request can also end it, but only while its qualifying enable is set. After a wake the controller counts input clock cycles before it re-enables the core clock. The count is long (4096 cycles) when the oscillator was stopped and has to settle again. It is short (100 cycles) when the oscillator was left running. A busy output is high for exactly the restart window. When restart ends, a context mode latched at commit decides the outcome: the core either resumes with its saved state, or receives a one-cycle clear strobe so that it starts clean. The synchronous reset input ends standby at once, from any state.

Top module: `pwrdn_seq_ctrl`

## Requirements
- R1: After reset, the core clock enable, oscillator enable and clock-output enable are 1, and the clear strobe, interrupt pulse and restart busy are 0.
- R2: While running, a rising edge of (request pin OR force bit) drives the interrupt pulse high in the next cycle for exactly one cycle. The core clock stays enabled.
- R3: A request held high raises no further pulse. Only a new rising edge, after the request has fallen, raises another.
- R4: Commit while a request is pending drops the core clock enable in the next cycle. The core clock stays on for any number of cycles before commit. Commit with no pending request has no effect.
- R5: While in standby, the oscillator enable is 0 exactly when the oscillator-stop mode was 1 in the commit cycle. Later changes of that input have no effect.
- R6: While in standby, the clock-output enable is 0 when the clock-output gate bit is 1, and 1 when the bit is 0. Outside standby it is 1.
- R7: With the oscillator stopped, a wake makes restart busy high for exactly 4096 cycles, starting in the cycle after the wake is sampled. The core clock enable rises in the cycle busy falls, and the oscillator enable is 1 throughout the restart.
- R8: With the oscillator left running, the same restart window lasts exactly 100 cycles.
- R9: A software reset request wakes the controller from standby only when its enable input is 1. Otherwise it is ignored.
- R10: The clear strobe pulses for one cycle, in the cycle the core clock enable returns, exactly when the context mode was 1 at commit.
- R11: Reset in any state returns the outputs to their R1 values in the next cycle.
- R12: Wake requests outside standby have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, counted during restart |
| rst | input | 1 | Synchronous active-high reset; also ends standby |
| pd_pin_i | input | 1 | External standby request |
| sw_force_i | input | 1 | Software standby force bit |
| commit_i | input | 1 | Core is ready to stop |
| wake_i | input | 1 | Wake request |
| sw_rst_req_i | input | 1 | Software reset request |
| sw_rst_wake_en_i | input | 1 | Lets a software reset end standby |
| xtal_stop_i | input | 1 | 1: stop the oscillator in standby (long restart) |
| ctx_clear_mode_i | input | 1 | 1: clear the context on exit |
| clkout_gate_i | input | 1 | 1: gate the clock output in standby |
| core_clk_en_o | output | 1 | Core clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| clkout_en_o | output | 1 | Clock-output pin enable |
| ctx_clear_o | output | 1 | One-cycle context clear strobe |
| pd_irq_o | output | 1 | One-cycle standby interrupt pulse |
| restart_busy_o | output | 1 | High during the restart wait |

## Verification
Every output is registered. So each response shows one cycle after the edge that samples its cause: the interrupt pulse after the request edge, the clock gating after commit, and busy after the wake. The bench changes inputs and samples outputs on the falling edge, so each check reads the result of exactly one rising edge. Restart length is measured by counting the falling edges at which busy is seen high before the core clock enable returns. That count must equal 4096 or 100. The clear strobe is checked on the same sample as the returning clock enable, and again one cycle later.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PEND = 2'd1,
    ST_DOWN = 2'd2,
    ST_WAIT = 2'd3
  } pd_state_e;
endpackage

// File: rtl/pwrdn_req_detect.sv
module pwrdn_req_detect (
  input  logic clk,
  input  logic rst,
  input  logic pd_pin_i,
  input  logic sw_force_i,
  input  logic wake_i,
  input  logic sw_rst_req_i,
  input  logic sw_rst_wake_en_i,
  output logic req_rise_o,
  output logic wake_o
);
  logic req_now;
  logic req_q;

  assign req_now = pd_pin_i | sw_force_i;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= req_now;
  end

  assign req_rise_o = req_now & ~req_q;
  assign wake_o     = wake_i | (sw_rst_req_i & sw_rst_wake_en_i);
endmodule

// File: rtl/pwrdn_restart_timer.sv
module pwrdn_restart_timer #(
  parameter int SLOW_CYCLES = 4096,
  parameter int FAST_CYCLES = 100,
  parameter int CNT_W       = $clog2(SLOW_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic slow_i,
  output logic done_o
);
  localparam logic [CNT_W-1:0] SLOW_LOAD = CNT_W'(SLOW_CYCLES - 1);
  localparam logic [CNT_W-1:0] FAST_LOAD = CNT_W'(FAST_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load_i)      cnt_q <= slow_i ? SLOW_LOAD : FAST_LOAD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pwrdn_fsm.sv
module pwrdn_fsm
  import pwrdn_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_rise_i,
  input  logic commit_i,
  input  logic wake_i,
  input  logic timer_done_i,
  input  logic xtal_stop_i,
  input  logic ctx_clear_mode_i,
  input  logic clkout_gate_i,
  output logic timer_load_o,
  output logic timer_slow_o,
  output logic core_clk_en_o,
  output logic osc_en_o,
  output logic clkout_en_o,
  output logic ctx_clear_o,
  output logic pd_irq_o,
  output logic restart_busy_o
);
  pd_state_e state_q, state_d;
  logic      osc_stop_q;
  logic      ctx_clear_q;
  logic      commit_now;
  logic      stop_eff;
  logic      exit_now;

  assign commit_now = (state_q == ST_PEND) && commit_i;
  assign exit_now   = (state_q == ST_WAIT) && timer_done_i;
  assign stop_eff   = commit_now ? xtal_stop_i : osc_stop_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (req_rise_i)   state_d = ST_PEND;
      ST_PEND: if (commit_i)     state_d = ST_DOWN;
      ST_DOWN: if (wake_i)       state_d = ST_WAIT;
      ST_WAIT: if (timer_done_i) state_d = ST_RUN;
      default:                   state_d = ST_RUN;
    endcase
  end

  assign timer_load_o = (state_q == ST_DOWN) && wake_i;
  assign timer_slow_o = osc_stop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_RUN;
      osc_stop_q     <= 1'b0;
      ctx_clear_q    <= 1'b0;
      core_clk_en_o  <= 1'b1;
      osc_en_o       <= 1'b1;
      clkout_en_o    <= 1'b1;
      ctx_clear_o    <= 1'b0;
      pd_irq_o       <= 1'b0;
      restart_busy_o <= 1'b0;
    end else begin
      state_q <= state_d;
      if (commit_now) begin
        osc_stop_q  <= xtal_stop_i;
        ctx_clear_q <= ctx_clear_mode_i;
      end
      core_clk_en_o  <= (state_d == ST_RUN) || (state_d == ST_PEND);
      osc_en_o       <= !((state_d == ST_DOWN) && stop_eff);
      clkout_en_o    <= !((state_d == ST_DOWN) && clkout_gate_i);
      ctx_clear_o    <= exit_now && ctx_clear_q;
      pd_irq_o       <= (state_q == ST_RUN) && req_rise_i;
      restart_busy_o <= (state_d == ST_WAIT);
    end
  end
endmodule

// File: rtl/pwrdn_seq_ctrl.sv
module pwrdn_seq_ctrl #(
  parameter int SLOW_CYCLES = 4096,
  parameter int FAST_CYCLES = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_pin_i,
  input  logic sw_force_i,
  input  logic commit_i,
  input  logic wake_i,
  input  logic sw_rst_req_i,
  input  logic sw_rst_wake_en_i,
  input  logic xtal_stop_i,
  input  logic ctx_clear_mode_i,
  input  logic clkout_gate_i,
  output logic core_clk_en_o,
  output logic osc_en_o,
  output logic clkout_en_o,
  output logic ctx_clear_o,
  output logic pd_irq_o,
  output logic restart_busy_o
);
  localparam int CNT_W = $clog2(SLOW_CYCLES + 1);

  logic req_rise;
  logic wake_any;
  logic tmr_load;
  logic tmr_slow;
  logic tmr_done;

  pwrdn_req_detect u_req (
    .clk              (clk),
    .rst              (rst),
    .pd_pin_i         (pd_pin_i),
    .sw_force_i       (sw_force_i),
    .wake_i           (wake_i),
    .sw_rst_req_i     (sw_rst_req_i),
    .sw_rst_wake_en_i (sw_rst_wake_en_i),
    .req_rise_o       (req_rise),
    .wake_o           (wake_any)
  );

  pwrdn_restart_timer #(
    .SLOW_CYCLES (SLOW_CYCLES),
    .FAST_CYCLES (FAST_CYCLES),
    .CNT_W       (CNT_W)
  ) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_load),
    .slow_i (tmr_slow),
    .done_o (tmr_done)
  );

  pwrdn_fsm u_fsm (
    .clk              (clk),
    .rst              (rst),
    .req_rise_i       (req_rise),
    .commit_i         (commit_i),
    .wake_i           (wake_any),
    .timer_done_i     (tmr_done),
    .xtal_stop_i      (xtal_stop_i),
    .ctx_clear_mode_i (ctx_clear_mode_i),
    .clkout_gate_i    (clkout_gate_i),
    .timer_load_o     (tmr_load),
    .timer_slow_o     (tmr_slow),
    .core_clk_en_o    (core_clk_en_o),
    .osc_en_o         (osc_en_o),
    .clkout_en_o      (clkout_en_o),
    .ctx_clear_o      (ctx_clear_o),
    .pd_irq_o         (pd_irq_o),
    .restart_busy_o   (restart_busy_o)
  );
endmodule

// File: rtl/pwrdn_seq_ctrl_chk.sv
module pwrdn_seq_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic core_clk_en_o,
  input logic osc_en_o,
  input logic clkout_en_o,
  input logic ctx_clear_o,
  input logic pd_irq_o,
  input logic restart_busy_o
);
  // R2
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    pd_irq_o |=> !pd_irq_o);

  // R7
  busy_holds_core_off_chk: assert property (@(posedge clk) disable iff (rst)
    restart_busy_o |-> !core_clk_en_o);

  // R10
  clear_at_exit_chk: assert property (@(posedge clk) disable iff (rst)
    ctx_clear_o |-> (core_clk_en_o && $past(restart_busy_o)));

  // R6
  clkout_off_in_standby_chk: assert property (@(posedge clk) disable iff (rst)
    !clkout_en_o |-> (!core_clk_en_o && !restart_busy_o));

  // R5
  osc_off_in_standby_chk: assert property (@(posedge clk) disable iff (rst)
    !osc_en_o |-> (!core_clk_en_o && !restart_busy_o));

  // R11
  reset_returns_run_chk: assert property (@(posedge clk)
    rst |=> (core_clk_en_o && osc_en_o && clkout_en_o && !restart_busy_o));
endmodule

bind pwrdn_seq_ctrl pwrdn_seq_ctrl_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .core_clk_en_o  (core_clk_en_o),
  .osc_en_o       (osc_en_o),
  .clkout_en_o    (clkout_en_o),
  .ctx_clear_o    (ctx_clear_o),
  .pd_irq_o       (pd_irq_o),
  .restart_busy_o (restart_busy_o)
);

// File: tb/pwrdn_seq_ctrl_test.sv
module pwrdn_seq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pd_pin = 0, sw_force = 0, commit = 0, wake = 0;
  logic sw_rst_req = 0, sw_rst_en = 0, xtal_stop = 0, ctx_mode = 0, clk_gate = 0;
  logic core_en, osc_en, clkout_en, ctx_clear, pd_irq, busy;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit ended    = 0;

  pwrdn_seq_ctrl uut (
    .clk(clk), .rst(rst), .pd_pin_i(pd_pin), .sw_force_i(sw_force),
    .commit_i(commit), .wake_i(wake), .sw_rst_req_i(sw_rst_req),
    .sw_rst_wake_en_i(sw_rst_en), .xtal_stop_i(xtal_stop),
    .ctx_clear_mode_i(ctx_mode), .clkout_gate_i(clk_gate),
    .core_clk_en_o(core_en), .osc_en_o(osc_en), .clkout_en_o(clkout_en),
    .ctx_clear_o(ctx_clear), .pd_irq_o(pd_irq), .restart_busy_o(busy)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_latency(bit stopped);
    return stopped ? 4096 : 100;
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WD_LIMIT && !ended) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(logic [31:0] act, logic [31:0] exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic chk_run_outputs(string tag);
    chk(core_en, 1, {tag, " core_clk_en"});
    chk(osc_en, 1, {tag, " osc_en"});
    chk(clkout_en, 1, {tag, " clkout_en"});
    chk(ctx_clear, 0, {tag, " ctx_clear"});
    chk(pd_irq, 0, {tag, " pd_irq"});
    chk(busy, 0, {tag, " restart_busy"});
  endtask

  task automatic enter_down(bit stop, bit gate);
    pd_pin = 1;
    step(1);
    pd_pin = 0;
    step(1);
    xtal_stop = stop; clk_gate = gate; commit = 1;
    step(1);
    commit = 0;
  endtask

  task automatic run_cycle(bit stop, bit ctxclr, bit gate, bit via_sw,
                           bit sw_wake, int idle, bit hold_req);
    int n;
    if (via_sw) sw_force = 1; else pd_pin = 1;
    step(1);
    chk(pd_irq, 1, "R2 irq after request edge");
    chk(core_en, 1, "R2 core on with irq");
    step(1);
    chk(pd_irq, 0, "R2 irq lasts one cycle");
    if (!hold_req) begin pd_pin = 0; sw_force = 0; end
    for (int k = 0; k < idle; k++) begin
      step(1);
      chk(core_en, 1, "R4 core runs while pending");
    end
    xtal_stop = stop; ctx_mode = ctxclr; clk_gate = gate; commit = 1;
    step(1);
    commit = 0; ctx_mode = !ctxclr; xtal_stop = !stop;
    chk(core_en, 0, "R4 core off after commit");
    chk(osc_en, !stop, "R5 osc per mode at commit");
    chk(clkout_en, !gate, "R6 clkout per gate bit");
    step(idle);
    chk(osc_en, !stop, "R5 osc latched after mode change");
    chk(busy, 0, "R7 no restart before wake");
    if (sw_wake) begin sw_rst_req = 1; sw_rst_en = 1; end else wake = 1;
    step(1);
    wake = 0; sw_rst_req = 0; sw_rst_en = 0;
    n = 0;
    while (busy && !core_en && n < 10000) begin
      if (!osc_en) chk(osc_en, 1, "R7 osc on during restart");
      n++;
      step(1);
    end
    chk(n, exp_latency(stop), stop ? (sw_wake ? "R7 R9 slow restart" : "R7 slow restart")
                                   : (sw_wake ? "R8 R9 fast restart" : "R8 fast restart"));
    chk(core_en, 1, "R7 core back on");
    chk(ctx_clear, ctxclr, "R10 clear strobe per mode");
    chk(clkout_en, 1, "R6 clkout on after exit");
    step(1);
    chk(ctx_clear, 0, "R10 strobe one cycle");
    ctx_mode = 0; xtal_stop = 0; clk_gate = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    step(1);
    chk_run_outputs("R1 reset");
    rst = 0;
    step(2);
    chk_run_outputs("R1 idle after reset");

    // R12: wake outside standby
    wake = 1; sw_rst_req = 1; sw_rst_en = 1;
    step(3);
    chk(busy, 0, "R12 wake ignored in run");
    chk(core_en, 1, "R12 core stays on");
    wake = 0; sw_rst_req = 0; sw_rst_en = 0;
    // R4: commit with nothing pending
    commit = 1;
    step(1);
    commit = 0;
    chk(core_en, 1, "R4 stray commit ignored");

    // directed corners
    run_cycle(1, 1, 1, 0, 0, 0, 0);
    run_cycle(0, 0, 0, 1, 1, 3, 0);
    run_cycle(0, 1, 0, 0, 0, 1, 1);
    // R3: request still held after return to run
    step(1);
    for (int k = 0; k < 3; k++) begin
      chk(pd_irq, 0, "R3 held request no repeat");
      step(1);
    end
    commit = 1;
    step(1);
    commit = 0;
    chk(core_en, 1, "R3 R4 held request not pending");
    pd_pin = 0;
    step(1);
    pd_pin = 1;
    step(1);
    chk(pd_irq, 1, "R3 new edge raises irq");
    pd_pin = 0;
    rst = 1;
    step(1);
    rst = 0;
    chk_run_outputs("R11 reset from pending");

    // R9: software reset without enable
    enter_down(1, 1);
    sw_rst_req = 1; sw_rst_en = 0;
    step(3);
    chk(busy, 0, "R9 sw reset ignored without enable");
    chk(core_en, 0, "R9 still in standby");
    sw_rst_req = 0;
    rst = 1;
    step(1);
    rst = 0;
    chk_run_outputs("R11 reset from standby");

    // R11: reset inside restart window
    enter_down(1, 0);
    wake = 1;
    step(1);
    wake = 0;
    step(50);
    chk(busy, 1, "R7 busy mid restart");
    rst = 1;
    step(1);
    rst = 0;
    chk_run_outputs("R11 reset from restart");

    // constrained random cycles
    for (int i = 0; i < 14; i++) begin
      bit st;
      st = ($urandom % 3) == 0;
      run_cycle(st, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                int'($urandom % 6), 0);
      step(int'($urandom % 4));
    end

    finish_run();
  end
endmodule